// File: doc/BRIEF.md
# Banked System Address Decoder

This block sits on a 32-bit CPU bus and sorts every access into one target region. It works at 4 KiB page granularity. Each request carries an address, a write strobe and a size (byte, halfword or word). One clock later the block returns four things: a one-hot region select, the offset of the access inside that region, a write enable and the wait-state count the access should see. The regions are main RAM, a legacy video window, an upper 32 KiB RAM, a banked 32 KiB window, extended RAM, video RAM, sprite RAM, two ROM-card slots, three read-only ROM windows, system ROM, a small learning RAM, a PCM wave window and unmapped space.

A bank flag that software can write decides what the top 32 KiB of the first megabyte holds. When the flag selects RAM, that window is a 32 KiB RAM. When it selects ROM, reads come from a fixed place inside system ROM and writes are dropped. The flag resets to the ROM setting, so the processor boots from ROM.

When a read hits no region, the block returns an all-ones fill value as wide as the access size, and it reports no wait states. The memories and devices behind each region sit outside this block.

Top module: `sys_addr_decoder`

## Requirements
- R1: A request presented with `req_valid` high at a rising clock edge produces its response on the outputs from that edge onward, with `rsp_valid` high. `rsp_valid` is low after any edge that saw `req_valid` low.
- R2: The 4 KiB pages 0x00000–0x000BF select main RAM with offset = address. Pages 0x000C0–0x000EF select the legacy video region with offset = address − 0x000C0000. Pages 0x000F0–0x000F7 select the upper RAM with offset = address[14:0].
- R3: The bank flag is 0 (ROM) after reset. A write through `bank_wr_en`/`bank_wr_ram` takes effect for requests sampled at later edges; a request sampled at the same edge still uses the old flag. For pages 0x000F8–0x000FF: flag 1 selects the banked RAM with offset address[14:0] and writes enabled; flag 0 selects system ROM with offset 0x38000 + address[14:0] and no write enable.
- R4: Extended RAM covers EXT_PAGES pages from 0x00100000, with offset = address − 0x00100000. The page just past its end is unmapped.
- R5: Video RAM covers VRAM_PAGES pages from 0x80000000 and VRAM_PAGES pages from 0x80100000, with offset = address − 0x80000000. Sprite RAM covers 0x81000000–0x8101FFFF with offset = address − 0x81000000.
- R6: ROM-card slot 0 covers 0xC0000000–0xC0FFFFFF and slot 1 covers 0xC1000000–0xC1FFFFFF. For both, offset = address[23:0], and writes are allowed.
- R7: The read-only windows are 0xC2000000–0xC207FFFF, 0xC2080000–0xC20FFFFF and 0xC2100000–0xC213FFFF, each with offset relative to its own base. System ROM sits at 0xFFFC0000–0xFFFFFFFF with offset = address − 0xFFFC0000. None of these windows ever asserts `rsp_wr_en`.
- R8: Pages 0xC2140–0xC2141 select the learning RAM, with offset = address − 0xC2140000. Page 0xC2200 selects the PCM window, with offset = address − 0xC2200000.
- R9: An access that hits no region selects the unmapped region with offset 0, wait 0 and no write enable. For a read, `rsp_fill` is 0xFF, 0xFFFF or 0xFFFFFFFF for `req_size` 0, 1 or 2 (3 is treated as word). `rsp_fill` is 0 for writes and for every mapped access.
- R10: Video RAM, sprite RAM and the legacy video region report `cfg_vid_wait`. Every other mapped region reports `cfg_mem_wait`.
- R11: `rsp_wr_en` is high only for a write to a writable region: any mapped region except system ROM and the three read-only windows. It is never high for a read.
- R12: `rsp_region` is one-hot with these bit positions:
  - 0 main
  - 1 legacy video
  - 2 upper RAM
  - 3 banked RAM
  - 4 system ROM
  - 5 extended RAM
  - 6 video
  - 7 sprite
  - 8 card 0
  - 9 card 1
  - 10, 11, 12 the read-only windows in ascending address order
  - 13 learning RAM
  - 14 PCM
  - 15 unmapped

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Address strobe |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| bank_wr_en | input | 1 | Load the bank flag |
| bank_wr_ram | input | 1 | New bank flag value, 1 = RAM |
| cfg_mem_wait | input | WAIT_W | Wait count for memory regions |
| cfg_vid_wait | input | WAIT_W | Wait count for video regions |
| rsp_valid | output | 1 | Response valid |
| rsp_region | output | 16 | One-hot region select |
| rsp_offset | output | 32 | Region-relative offset |
| rsp_wr_en | output | 1 | Write enable gate |
| rsp_wait | output | WAIT_W | Wait-state count |
| rsp_fill | output | 32 | All-ones read data for unmapped reads |
| bank_is_ram | output | 1 | Current bank flag |

## Verification
The hardest case to reach from the ports is a bank flag write in the same cycle as an access to the banked window. The old flag must still apply to that access, and the new flag must apply to the very next one. The bench issues the flag write and the window access together, then issues a second access right behind them. It also sweeps every page of the first two megabytes and of the video and ROM areas. Each window's first and last page are paired with the unmapped pages on either side, so every boundary is checked from both directions.

// File: rtl/sad_pkg.sv
// Shared region encoding and per-region attributes for the address decoder.
// Assumes the region index doubles as the bit position of the one-hot select.
package sad_pkg;
    localparam int NUM_REGIONS = 16;

    typedef enum logic [3:0] {
        RG_MAIN    = 4'd0,
        RG_LVID    = 4'd1,
        RG_UPRAM   = 4'd2,
        RG_BANKRAM = 4'd3,
        RG_SYSROM  = 4'd4,
        RG_EXTRAM  = 4'd5,
        RG_VRAM    = 4'd6,
        RG_SPRITE  = 4'd7,
        RG_CARD0   = 4'd8,
        RG_CARD1   = 4'd9,
        RG_ROM_LO  = 4'd10,
        RG_ROM_MID = 4'd11,
        RG_ROM_HI  = 4'd12,
        RG_LEARN   = 4'd13,
        RG_PCM     = 4'd14,
        RG_NONE    = 4'd15
    } region_e;

    // True when a write may be passed on to the region.
    function automatic logic region_writable(region_e r);
        return !(r == RG_SYSROM || r == RG_ROM_LO || r == RG_ROM_MID ||
                 r == RG_ROM_HI || r == RG_NONE);
    endfunction

    // True when the region takes the video wait count.
    function automatic logic region_video(region_e r);
        return (r == RG_VRAM || r == RG_SPRITE || r == RG_LVID);
    endfunction
endpackage

// File: rtl/sad_page_classify.sv
// Page classifier: maps the 20-bit page index to a region.
// Assumes VRAM_PAGES <= 256 so the two video windows never overlap,
// and EXT_PAGES keeps extended RAM below the video area.
module sad_page_classify
    import sad_pkg::*;
#(
    parameter int EXT_PAGES  = 256,
    parameter int VRAM_PAGES = 128
) (
    input  logic [19:0] page,
    input  logic        bank_ram,
    output region_e     region
);
    localparam logic [19:0] EXT_END  = 20'h00100 + 20'(EXT_PAGES);
    localparam logic [19:0] VID0_END = 20'h80000 + 20'(VRAM_PAGES);
    localparam logic [19:0] VID1_END = 20'h80100 + 20'(VRAM_PAGES);

    // Ordered range compare over the irregular map.
    always_comb begin
        if (page < 20'h000C0)                           region = RG_MAIN;
        else if (page < 20'h000F0)                      region = RG_LVID;
        else if (page < 20'h000F8)                      region = RG_UPRAM;
        else if (page < 20'h00100)                      region = bank_ram ? RG_BANKRAM : RG_SYSROM;
        else if (page < EXT_END)                        region = RG_EXTRAM;
        else if (page >= 20'h80000 && page < VID0_END)  region = RG_VRAM;
        else if (page >= 20'h80100 && page < VID1_END)  region = RG_VRAM;
        else if (page >= 20'h81000 && page < 20'h81020) region = RG_SPRITE;
        else if (page >= 20'hC0000 && page < 20'hC1000) region = RG_CARD0;
        else if (page >= 20'hC1000 && page < 20'hC2000) region = RG_CARD1;
        else if (page >= 20'hC2000 && page < 20'hC2080) region = RG_ROM_LO;
        else if (page >= 20'hC2080 && page < 20'hC2100) region = RG_ROM_MID;
        else if (page >= 20'hC2100 && page < 20'hC2140) region = RG_ROM_HI;
        else if (page >= 20'hC2140 && page < 20'hC2142) region = RG_LEARN;
        else if (page == 20'hC2200)                     region = RG_PCM;
        else if (page >= 20'hFFFC0)                     region = RG_SYSROM;
        else                                            region = RG_NONE;
    end
endmodule

// File: rtl/sad_offset_gen.sv
// Offset generator: subtracts the region base (or masks) to give the
// region-relative offset. The system ROM region has two sources: the
// banked shadow in the first megabyte and the top-of-space window.
module sad_offset_gen
    import sad_pkg::*;
(
    input  logic [31:0] addr,
    input  region_e     region,
    output logic [31:0] offset
);
    logic shadow;
    assign shadow = (addr[31:20] == 12'h000);

    // Per-region base removal.
    always_comb begin
        unique case (region)
            RG_MAIN:    offset = addr;
            RG_LVID:    offset = addr - 32'h000C0000;
            RG_UPRAM,
            RG_BANKRAM: offset = {17'd0, addr[14:0]};
            RG_SYSROM:  offset = shadow ? (32'h00038000 + {17'd0, addr[14:0]})
                                        : (addr - 32'hFFFC0000);
            RG_EXTRAM:  offset = addr - 32'h00100000;
            RG_VRAM:    offset = addr - 32'h80000000;
            RG_SPRITE:  offset = addr - 32'h81000000;
            RG_CARD0,
            RG_CARD1:   offset = {8'd0, addr[23:0]};
            RG_ROM_LO:  offset = addr - 32'hC2000000;
            RG_ROM_MID: offset = addr - 32'hC2080000;
            RG_ROM_HI:  offset = addr - 32'hC2100000;
            RG_LEARN:   offset = addr - 32'hC2140000;
            RG_PCM:     offset = addr - 32'hC2200000;
            default:    offset = 32'd0;
        endcase
    end
endmodule

// File: rtl/sad_bank_flag.sv
// Bank flag register: 1 = RAM in the banked window, 0 = system ROM.
// Resets to ROM so the first fetches come from system ROM.
module sad_bank_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_ram,
    output logic bank_ram
);
    // Hold the flag; load on a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)     bank_ram <= 1'b0;
        else if (wr_en) bank_ram <= wr_ram;
    end
endmodule

// File: rtl/sys_addr_decoder.sv
// Banked system address decoder, top level. Classifies each bus access,
// derives offset, write gate, wait count and unmapped fill, and registers
// the result so it appears one clock after the strobe.
// Assumes the configuration wait inputs are quasi-static.
module sys_addr_decoder
    import sad_pkg::*;
#(
    parameter int EXT_PAGES  = 256,
    parameter int VRAM_PAGES = 128,
    parameter int WAIT_W     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [31:0]            req_addr,
    input  logic                   req_write,
    input  logic [1:0]             req_size,
    input  logic                   bank_wr_en,
    input  logic                   bank_wr_ram,
    input  logic [WAIT_W-1:0]      cfg_mem_wait,
    input  logic [WAIT_W-1:0]      cfg_vid_wait,
    output logic                   rsp_valid,
    output logic [NUM_REGIONS-1:0] rsp_region,
    output logic [31:0]            rsp_offset,
    output logic                   rsp_wr_en,
    output logic [WAIT_W-1:0]      rsp_wait,
    output logic [31:0]            rsp_fill,
    output logic                   bank_is_ram
);
    region_e                region_d;
    logic [31:0]            offset_d;
    logic [NUM_REGIONS-1:0] onehot_d;
    logic                   wr_en_d;
    logic [WAIT_W-1:0]      wait_d;
    logic [31:0]            fill_d;

    sad_bank_flag u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bank_wr_en),
        .wr_ram   (bank_wr_ram),
        .bank_ram (bank_is_ram)
    );

    sad_page_classify #(
        .EXT_PAGES  (EXT_PAGES),
        .VRAM_PAGES (VRAM_PAGES)
    ) u_class (
        .page     (req_addr[31:12]),
        .bank_ram (bank_is_ram),
        .region   (region_d)
    );

    sad_offset_gen u_off (
        .addr   (req_addr),
        .region (region_d),
        .offset (offset_d)
    );

    // One-hot select, one comparator per region.
    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_sel
        assign onehot_d[i] = (region_d == region_e'(i));
    end

    // Attribute lookup: write gate, wait count, unmapped fill.
    always_comb begin
        wr_en_d = req_write && region_writable(region_d);
        if (region_d == RG_NONE)        wait_d = '0;
        else if (region_video(region_d)) wait_d = cfg_vid_wait;
        else                             wait_d = cfg_mem_wait;
        fill_d = 32'd0;
        if (region_d == RG_NONE && !req_write) begin
            unique case (req_size)
                2'd0:    fill_d = 32'h000000FF;
                2'd1:    fill_d = 32'h0000FFFF;
                default: fill_d = 32'hFFFFFFFF;
            endcase
        end
    end

    // Response register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_region <= NUM_REGIONS'(1) << RG_NONE;
            rsp_offset <= '0;
            rsp_wr_en  <= 1'b0;
            rsp_wait   <= '0;
            rsp_fill   <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_region <= onehot_d;
            rsp_offset <= offset_d;
            rsp_wr_en  <= wr_en_d && req_valid;
            rsp_wait   <= wait_d;
            rsp_fill   <= fill_d;
        end
    end
endmodule

// File: rtl/sad_checker.sv
// Assertion checker for sys_addr_decoder, attached through bind.
module sad_checker
    import sad_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_write,
    input logic                   rsp_valid,
    input logic [NUM_REGIONS-1:0] rsp_region,
    input logic                   rsp_wr_en,
    input logic [WAIT_W-1:0]      rsp_wait,
    input logic [31:0]            rsp_fill,
    input logic                   bank_wr_en,
    input logic                   bank_is_ram
);
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R1
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_wr_en |=> $stable(bank_is_ram)); // R3
    AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_region[RG_SYSROM] || rsp_region[RG_ROM_LO] ||
         rsp_region[RG_ROM_MID] || rsp_region[RG_ROM_HI])) |-> !rsp_wr_en); // R7
    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_region[RG_NONE]) |-> (rsp_wait == '0 && !rsp_wr_en)); // R9
    AST_FILL_ONLY_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_region[RG_NONE]) |-> (rsp_fill == 32'd0)); // R9
    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> !rsp_wr_en); // R11
    AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones(rsp_region) == 1)); // R12
endmodule

bind sys_addr_decoder sad_checker #(.WAIT_W(WAIT_W)) u_sad_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .rsp_valid   (rsp_valid),
    .rsp_region  (rsp_region),
    .rsp_wr_en   (rsp_wr_en),
    .rsp_wait    (rsp_wait),
    .rsp_fill    (rsp_fill),
    .bank_wr_en  (bank_wr_en),
    .bank_is_ram (bank_is_ram)
);

// File: tb/tb_sys_addr_decoder.sv
// Bench: page sweeps with an arithmetic reference model.
module tb_sys_addr_decoder;
    localparam int EXT_PAGES  = 256;
    localparam int VRAM_PAGES = 128;
    localparam int WAIT_W     = 4;
    localparam logic [3:0] MEMW = 4'd3;
    localparam logic [3:0] VIDW = 4'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic        bank_wr_en = 1'b0;
    logic        bank_wr_ram = 1'b0;
    logic [3:0]  cfg_mem_wait = MEMW;
    logic [3:0]  cfg_vid_wait = VIDW;
    logic        rsp_valid;
    logic [15:0] rsp_region;
    logic [31:0] rsp_offset;
    logic        rsp_wr_en;
    logic [3:0]  rsp_wait;
    logic [31:0] rsp_fill;
    logic        bank_is_ram;

    int checks = 0;
    int errors = 0;
    bit model_bank = 1'b0;

    always #5 clk = ~clk;

    sys_addr_decoder #(.EXT_PAGES(EXT_PAGES), .VRAM_PAGES(VRAM_PAGES), .WAIT_W(WAIT_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .bank_wr_en(bank_wr_en),
        .bank_wr_ram(bank_wr_ram), .cfg_mem_wait(cfg_mem_wait), .cfg_vid_wait(cfg_vid_wait),
        .rsp_valid(rsp_valid), .rsp_region(rsp_region), .rsp_offset(rsp_offset),
        .rsp_wr_en(rsp_wr_en), .rsp_wait(rsp_wait), .rsp_fill(rsp_fill),
        .bank_is_ram(bank_is_ram)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference map: region index, offset and requirement tag.
    task automatic model(input logic [31:0] a, input bit bank, output int rg,
                         output logic [31:0] off, output string tag);
        logic [19:0] p;
        p = a[31:12];
        off = 32'd0;
        if (p < 20'hC0)                     begin rg = 0;  off = a;               tag = "R2"; end
        else if (p < 20'hF0)                begin rg = 1;  off = a - 32'hC0000;   tag = "R2"; end
        else if (p < 20'hF8)                begin rg = 2;  off = a & 32'h7FFF;    tag = "R2"; end
        else if (p < 20'h100) begin
            tag = "R3";
            if (bank) begin rg = 3; off = a & 32'h7FFF; end
            else      begin rg = 4; off = 32'h38000 + (a & 32'h7FFF); end
        end
        else if (p < 20'h100 + EXT_PAGES)   begin rg = 5;  off = a - 32'h100000;  tag = "R4"; end
        else if ((p >= 20'h80000 && p < 20'h80000 + VRAM_PAGES) ||
                 (p >= 20'h80100 && p < 20'h80100 + VRAM_PAGES))
                                            begin rg = 6;  off = a - 32'h80000000; tag = "R5"; end
        else if (p >= 20'h81000 && p < 20'h81020) begin rg = 7; off = a - 32'h81000000; tag = "R5"; end
        else if (p >= 20'hC0000 && p < 20'hC1000) begin rg = 8; off = a & 32'hFFFFFF; tag = "R6"; end
        else if (p >= 20'hC1000 && p < 20'hC2000) begin rg = 9; off = a & 32'hFFFFFF; tag = "R6"; end
        else if (p >= 20'hC2000 && p < 20'hC2080) begin rg = 10; off = a - 32'hC2000000; tag = "R7"; end
        else if (p >= 20'hC2080 && p < 20'hC2100) begin rg = 11; off = a - 32'hC2080000; tag = "R7"; end
        else if (p >= 20'hC2100 && p < 20'hC2140) begin rg = 12; off = a - 32'hC2100000; tag = "R7"; end
        else if (p >= 20'hC2140 && p < 20'hC2142) begin rg = 13; off = a - 32'hC2140000; tag = "R8"; end
        else if (p == 20'hC2200)                  begin rg = 14; off = a - 32'hC2200000; tag = "R8"; end
        else if (p >= 20'hFFFC0)                  begin rg = 4;  off = a - 32'hFFFC0000; tag = "R7"; end
        else                                      begin rg = 15; tag = "R9"; end
    endtask

    // One access: drive away from the edge, sample one edge later.
    task automatic access(input logic [31:0] a, input bit wr, input logic [1:0] sz);
        int rg;
        logic [31:0] off, fill;
        string tag;
        bit wen;
        logic [3:0] w;
        model(a, model_bank, rg, off, tag);
        wen = wr && !(rg == 4 || rg == 10 || rg == 11 || rg == 12 || rg == 15);
        w = (rg == 15) ? 4'd0 : ((rg == 1 || rg == 6 || rg == 7) ? VIDW : MEMW);
        fill = 32'd0;
        if (rg == 15 && !wr) fill = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFFFFFF;
        req_valid = 1'b1; req_addr = a; req_write = wr; req_size = sz;
        @(posedge clk); #1;
        check({tag, " region/offset R12"}, {rsp_valid, rsp_region, rsp_offset},
              {1'b1, 16'(1) << rg, off});
        check("R10 R11 R9 attributes", {rsp_wr_en, rsp_wait, rsp_fill}, {wen, w, fill});
    endtask

    task automatic sweep(input logic [19:0] first, input logic [19:0] last);
        for (logic [20:0] p = {1'b0, first}; p <= {1'b0, last}; p++) begin
            logic [31:0] a;
            a = {p[19:0], 12'(p * 37)};
            access(a, p[0], 2'(p % 3));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R3 reset flag / R1 reset valid", {bank_is_ram, rsp_valid}, 2'b00);
        rst_n = 1'b1;
        // R1: idle cycle gives no response
        @(posedge clk); #1;
        check("R1 idle", rsp_valid, 1'b0);

        sweep(20'h00000, 20'h00201);              // R2 R3 R4 boundaries
        sweep(20'h7FFFF, 20'h80181);              // R5 both windows
        sweep(20'h80FFF, 20'h81021);              // R5 sprite
        sweep(20'hC0FFE, 20'hC1001);              // R6 slot edge
        sweep(20'hC1FFF, 20'hC2201);              // R7 R8
        sweep(20'hFFFBE, 20'hFFFFF);              // R7 system ROM
        access(32'h0000_0000, 1'b1, 2'd2);        // R2 first byte
        access(32'hBFFF_FFFF, 1'b0, 2'd0);        // R9 byte fill
        access(32'h4000_0000, 1'b0, 2'd1);        // R9 half fill
        access(32'h9000_0000, 1'b0, 2'd3);        // R9 size 3 as word
        access(32'hC200_0000, 1'b1, 2'd2);        // R7 write dropped
        access(32'hFFFF_FFFC, 1'b1, 2'd2);        // R7 write dropped
        access(32'h000F_8ABC, 1'b1, 2'd2);        // R3 ROM setting
        // R3: flag write together with an access; old flag applies
        bank_wr_en = 1'b1; bank_wr_ram = 1'b1;
        access(32'h000F_F123, 1'b1, 2'd1);
        bank_wr_en = 1'b0;
        model_bank = 1'b1;
        check("R3 flag now RAM", bank_is_ram, 1'b1);
        access(32'h000F_F124, 1'b1, 2'd1);        // R3 new flag applies
        sweep(20'h000F7, 20'h00100);              // R3 RAM setting
        bank_wr_en = 1'b1; bank_wr_ram = 1'b0;
        access(32'h000F_8000, 1'b0, 2'd0);
        bank_wr_en = 1'b0;
        model_bank = 1'b0;
        access(32'h000F_8000, 1'b0, 2'd0);        // R3 back to ROM
        req_valid = 1'b0;
        @(posedge clk); #1;
        check("R1 valid drops", rsp_valid, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule